// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This block is a two-wire bus master sequencer for serial memories. It runs right after a write has been sent to the memory, while the memory is busy with its internal programming cycle. During that cycle the memory ignores its address, so the block probes it again and again. Each probe is a start condition followed by the device address with the direction bit cleared. While the memory stays silent in the acknowledge slot, the block closes the probe with a stop and tries again. The first acknowledge means the programming cycle is over.

What happens next depends on the operation the host asked for. If the next operation is a write, the block sends the target byte address at once and keeps the bus, with SCL held low, so the data phase can follow. If the next operation is a read, the block sends a stop and frees the bus so a read can start. A limit on the number of probes ends a hopeless poll with a timeout flag. SCL comes from an internal tick divider. SDA is open-drain: the block only pulls it low or lets it go.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset SCL is high, SDA is released (`sda_pull_low` = 0), and `busy` and `done` are low.
- R2: A `cmd_valid` pulse seen while `busy` is low is accepted: `busy` is high from the next cycle, and `poll_count` starts again from zero.
- R3: Each attempt is a start condition (SDA falls while SCL is high), then eight bits `{cmd_dev_addr, 1'b0}`, MSB first, each valid while SCL is high, then a ninth bit with SDA released. A low SDA at the rising SCL edge of that ninth bit is an acknowledge.
- R4: If the ninth bit of an attempt is high (no acknowledge) and the limit is not yet reached, the block sends a stop condition (SDA rises while SCL is high) and then starts a new attempt.
- R5: After an acknowledge with `cmd_next_write` = 1, the block sends the eight bits of `cmd_byte_addr`, MSB first, and then a released ninth bit. It sends no stop. It then pulses `done` and leaves SCL low and SDA released.
- R6: After an acknowledge with `cmd_next_write` = 0, the block sends exactly one stop, then pulses `done` and leaves SCL high and SDA released.
- R7: `poll_count` equals the number of attempts made for the current command. A value of 1 means the first attempt was acknowledged. It never exceeds MAX_POLLS.
- R8: If MAX_POLLS attempts all go unacknowledged, the block sends a stop, pulses `done` with `timeout` = 1, and leaves `poll_count` = MAX_POLLS. A command that ends with an acknowledge reports `timeout` = 0.
- R9: `done` is high for exactly one cycle, in the same cycle that `busy` falls. `timeout` holds its value from that point until the next command is accepted.
- R10: `cmd_valid` while `busy` is high has no effect: the address bits on the bus and the way the command ends follow the command already accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start a poll sequence (taken only when idle) |
| cmd_dev_addr | input | 7 | Seven-bit device address |
| cmd_next_write | input | 1 | 1: next operation is a write, 0: a read |
| cmd_byte_addr | input | 8 | Byte address sent after the acknowledge for a write |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_out | output | 1 | SCL level driven by the master |
| sda_pull_low | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence ends |
| timeout | output | 1 | Last sequence hit the probe limit |
| poll_count | output | CNT_W | Attempts made for the current command |

## Verification
The assertions assume that `rst_n` starts low and that the command fields are only sampled on the cycle in which a command is accepted. They also assume that nothing about `poll_count` or `timeout` is expected to change while the block is idle unless a new command arrives. The stimulus stays inside these assumptions by holding each command for one cycle at a falling clock edge while the block is idle. It also includes deliberate extra pulses during busy periods, which the block must drop. A bus-level memory model drives SDA only between SCL edges. It acknowledges from a chosen attempt number onward, and that attempt number is sometimes set beyond the limit to force the timeout path.

// File: rtl/ap_pkg.sv
package ap_pkg;

   localparam int DEV_BITS  = 7;
   localparam int BYTE_BITS = 8;
   localparam int SLOT_BITS = BYTE_BITS + 1;

   typedef enum logic [1:0] {OP_START, OP_STOP, OP_BIT} bus_op_e;

   typedef struct packed {
      logic scl;
      logic sda_low;
   } line_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_ADDR, ST_RETRY_STOP,
      ST_BADDR, ST_READ_STOP, ST_TO_STOP
   } poll_st_e;

   // Line levels for each quarter of a bus slot.
   function automatic line_t phase_lines(bus_op_e op, logic b, logic [1:0] ph);
      line_t l;
      case (op)
         OP_START: begin
            l.scl     = (ph == 2'd1) || (ph == 2'd2);
            l.sda_low = ph[1];
         end
         OP_STOP: begin
            l.scl     = (ph != 2'd0);
            l.sda_low = !ph[1];
         end
         default: begin
            l.scl     = (ph == 2'd1) || (ph == 2'd2);
            l.sda_low = !b;
         end
      endcase
      return l;
   endfunction

endpackage

// File: rtl/ap_tick_gen.sv
module ap_tick_gen #(
   parameter int TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (TICK_DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(TICK_DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else if (!run || cnt == CW'(TICK_DIV - 1)) cnt <= '0;
            else cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == CW'(TICK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/ap_bit_engine.sv
module ap_bit_engine
   import ap_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    tick,
   input  logic    go,
   input  bus_op_e op,
   input  logic    bit_val,
   input  logic    sda_in,
   output logic    active,
   output logic    slot_done,
   output logic    sampled,
   output logic    scl,
   output logic    sda_low
);
   logic [1:0] ph;
   bus_op_e    op_q;
   logic       bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         slot_done <= 1'b0;
         sampled   <= 1'b1;
         ph        <= 2'd0;
         op_q      <= OP_STOP;
         bit_q     <= 1'b1;
         scl       <= 1'b1;
         sda_low   <= 1'b0;
      end else begin
         slot_done <= 1'b0;
         if (go && !active) begin
            active          <= 1'b1;
            ph              <= 2'd0;
            op_q            <= op;
            bit_q           <= bit_val;
            {scl, sda_low}  <= phase_lines(op, bit_val, 2'd0);
         end else if (active && tick) begin
            if (ph == 2'd3) begin
               active    <= 1'b0;
               slot_done <= 1'b1;
            end else begin
               ph             <= ph + 2'd1;
               {scl, sda_low} <= phase_lines(op_q, bit_q, ph + 2'd1);
               if (ph == 2'd0) sampled <= sda_in;   // line level as SCL rises
            end
         end
      end
   end
endmodule

// File: rtl/ap_poll_fsm.sv
module ap_poll_fsm
   import ap_pkg::*;
#(
   parameter int MAX_POLLS = 64,
   parameter int CNT_W     = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [DEV_BITS-1:0]  cmd_dev_addr,
   input  logic                 cmd_next_write,
   input  logic [BYTE_BITS-1:0] cmd_byte_addr,
   input  logic                 eng_active,
   input  logic                 eng_done,
   input  logic                 eng_sampled,
   output logic                 go,
   output bus_op_e              op,
   output logic                 bit_val,
   output logic                 busy,
   output logic                 done,
   output logic                 timeout,
   output logic [CNT_W-1:0]     poll_count
);
   localparam int IDX_W = $clog2(SLOT_BITS);

   poll_st_e             st;
   logic                 pend;
   logic [IDX_W-1:0]     idx;
   logic [BYTE_BITS-1:0] sh;
   logic [DEV_BITS-1:0]  dev_q;
   logic [BYTE_BITS-1:0] baddr_q;
   logic                 wr_q;
   logic                 last_slot;

   assign last_slot = (idx == IDX_W'(SLOT_BITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         pend       <= 1'b0;
         idx        <= '0;
         sh         <= '0;
         dev_q      <= '0;
         baddr_q    <= '0;
         wr_q       <= 1'b0;
         go         <= 1'b0;
         op         <= OP_STOP;
         bit_val    <= 1'b1;
         busy       <= 1'b0;
         done       <= 1'b0;
         timeout    <= 1'b0;
         poll_count <= '0;
      end else begin
         go   <= 1'b0;
         done <= 1'b0;
         if (st == ST_IDLE) begin
            if (cmd_valid) begin
               dev_q      <= cmd_dev_addr;
               wr_q       <= cmd_next_write;
               baddr_q    <= cmd_byte_addr;
               poll_count <= '0;
               timeout    <= 1'b0;
               busy       <= 1'b1;
               pend       <= 1'b0;
               st         <= ST_START;
            end
         end else if (!pend && !eng_active) begin
            go   <= 1'b1;
            pend <= 1'b1;
            case (st)
               ST_START: begin
                  op         <= OP_START;
                  poll_count <= poll_count + 1'b1;
               end
               ST_ADDR, ST_BADDR: begin
                  op      <= OP_BIT;
                  bit_val <= last_slot ? 1'b1 : sh[BYTE_BITS-1];
               end
               default: op <= OP_STOP;
            endcase
         end else if (eng_done) begin
            pend <= 1'b0;
            case (st)
               ST_START: begin
                  st  <= ST_ADDR;
                  idx <= '0;
                  sh  <= {dev_q, 1'b0};
               end
               ST_ADDR: begin
                  if (!last_slot) begin
                     idx <= idx + 1'b1;
                     sh  <= sh << 1;
                  end else if (!eng_sampled) begin
                     if (wr_q) begin
                        st  <= ST_BADDR;
                        idx <= '0;
                        sh  <= baddr_q;
                     end else begin
                        st <= ST_READ_STOP;
                     end
                  end else if (poll_count == CNT_W'(MAX_POLLS)) begin
                     st <= ST_TO_STOP;
                  end else begin
                     st <= ST_RETRY_STOP;
                  end
               end
               ST_RETRY_STOP: st <= ST_START;
               ST_BADDR: begin
                  if (!last_slot) begin
                     idx <= idx + 1'b1;
                     sh  <= sh << 1;
                  end else begin
                     st   <= ST_IDLE;
                     busy <= 1'b0;
                     done <= 1'b1;
                  end
               end
               ST_READ_STOP, ST_TO_STOP: begin
                  st      <= ST_IDLE;
                  busy    <= 1'b0;
                  done    <= 1'b1;
                  timeout <= (st == ST_TO_STOP);
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/ack_poll_seq.sv
module ack_poll_seq
   import ap_pkg::*;
#(
   parameter int TICK_DIV    = 125,
   parameter int MAX_POLLS   = 64,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(MAX_POLLS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [DEV_BITS-1:0]  cmd_dev_addr,
   input  logic                 cmd_next_write,
   input  logic [BYTE_BITS-1:0] cmd_byte_addr,
   input  logic                 sda_in,
   output logic                 scl_out,
   output logic                 sda_pull_low,
   output logic                 busy,
   output logic                 done,
   output logic                 timeout,
   output logic [CNT_W-1:0]     poll_count
);
   generate
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (MAX_POLLS < 1) begin : g_bad_max
         $error("MAX_POLLS must be at least 1");
      end
      if (SYNC_STAGES < 0 || TICK_DIV < SYNC_STAGES + 2) begin : g_bad_sync
         $error("TICK_DIV must exceed SYNC_STAGES + 1");
      end
   endgenerate

   logic    sda_s, tick, go, bit_val, eng_active, eng_done, eng_sampled;
   bus_op_e op;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sda_s = sda_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], sda_in};
         end
         assign sda_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   ap_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(eng_active), .tick(tick)
   );

   ap_bit_engine u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .op(op),
      .bit_val(bit_val), .sda_in(sda_s), .active(eng_active),
      .slot_done(eng_done), .sampled(eng_sampled),
      .scl(scl_out), .sda_low(sda_pull_low)
   );

   ap_poll_fsm #(.MAX_POLLS(MAX_POLLS), .CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
      .cmd_dev_addr(cmd_dev_addr), .cmd_next_write(cmd_next_write),
      .cmd_byte_addr(cmd_byte_addr), .eng_active(eng_active),
      .eng_done(eng_done), .eng_sampled(eng_sampled), .go(go), .op(op),
      .bit_val(bit_val), .busy(busy), .done(done), .timeout(timeout),
      .poll_count(poll_count)
   );
endmodule

// File: rtl/ack_poll_seq_chk.sv
module ack_poll_seq_chk #(
   parameter int MAX_POLLS = 64,
   localparam int CNT_W    = $clog2(MAX_POLLS + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic             busy,
   input logic             done,
   input logic             timeout,
   input logic [CNT_W-1:0] poll_count
);
   assert_busy_on_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy) |=> busy);

   assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      poll_count <= CNT_W'(MAX_POLLS));

   assert_count_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> poll_count >= $past(poll_count));

   assert_timeout_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && timeout) |-> poll_count == CNT_W'(MAX_POLLS));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_with_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_timeout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cmd_valid) |=> $stable(timeout));
endmodule

bind ack_poll_seq ack_poll_seq_chk #(.MAX_POLLS(MAX_POLLS)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
   .done(done), .timeout(timeout), .poll_count(poll_count)
);

// File: tb/tb_ack_poll_seq.sv
module tb_ack_poll_seq;
   localparam int TICK_DIV  = 4;
   localparam int MAX_POLLS = 6;
   localparam int CNT_W     = $clog2(MAX_POLLS + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_next_write = 1'b0;
   logic [6:0] cmd_dev_addr = '0;
   logic [7:0] cmd_byte_addr = '0;
   logic scl_out, sda_pull_low, busy, done, timeout;
   logic [CNT_W-1:0] poll_count;
   logic dev_low = 1'b0;
   logic sda_bus;

   int n_checks = 0, n_fail = 0;

   always #5 clk = ~clk;

   assign sda_bus = !(sda_pull_low || dev_low);

   ack_poll_seq #(.TICK_DIV(TICK_DIV), .MAX_POLLS(MAX_POLLS), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dev_addr(cmd_dev_addr),
      .cmd_next_write(cmd_next_write), .cmd_byte_addr(cmd_byte_addr),
      .sda_in(sda_bus), .scl_out(scl_out), .sda_pull_low(sda_pull_low),
      .busy(busy), .done(done), .timeout(timeout), .poll_count(poll_count)
   );

   // ---------------- memory model on the bus ----------------
   logic dev_clr = 1'b0;
   int   ack_from = 1;
   logic [7:0] exp_addr_byte = '0;
   int   starts, stops, attempts, bitcnt, byteidx, bad_addr, got_baddr;
   logic [7:0] sh, last_baddr;
   logic prev_scl = 1'b1, prev_sda = 1'b1;

   always @(negedge clk) begin
      if (dev_clr) begin
         starts = 0; stops = 0; attempts = 0; bitcnt = 0; byteidx = 0;
         bad_addr = 0; got_baddr = 0; sh = '0; last_baddr = '0; dev_low <= 1'b0;
      end else begin
         if (prev_scl && scl_out && prev_sda && !sda_bus) begin
            starts++; attempts++; bitcnt = 0; byteidx = 0;
         end else if (prev_scl && scl_out && !prev_sda && sda_bus) begin
            stops++;
         end else if (!prev_scl && scl_out) begin
            if (bitcnt < 8) begin
               sh = {sh[6:0], sda_bus};
               bitcnt++;
               if (bitcnt == 8) begin
                  if (byteidx == 0 && sh != exp_addr_byte) bad_addr++;
                  if (byteidx == 1) begin last_baddr = sh; got_baddr++; end
               end
            end else bitcnt++;
         end else if (prev_scl && !scl_out) begin
            if (bitcnt == 8)
               dev_low <= (byteidx == 0) ? (attempts >= ack_from) : 1'b1;
            else if (bitcnt == 9) begin
               dev_low <= 1'b0; bitcnt = 0; byteidx++;
            end
         end
      end
      prev_scl = scl_out;
      prev_sda = sda_bus;
   end

   // ---------------- checking helpers ----------------
   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_count(int k);
      return (k <= MAX_POLLS) ? k : MAX_POLLS;
   endfunction

   function automatic int exp_stops(int k, bit wr);
      if (k > MAX_POLLS) return MAX_POLLS;
      return (k - 1) + (wr ? 0 : 1);
   endfunction

   task automatic run_case(input logic [6:0] dev, input bit wr, input logic [7:0] baddr,
                           input int k, input bit poke);
      bit to;
      int waited;
      to = (k > MAX_POLLS);
      @(negedge clk);
      ack_from = k;
      exp_addr_byte = {dev, 1'b0};
      dev_clr = 1'b1;
      @(negedge clk);
      dev_clr = 1'b0;
      cmd_dev_addr = dev; cmd_next_write = wr; cmd_byte_addr = baddr; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R2", "busy after command", busy, 1);
      if (poke) begin
         repeat (60) @(negedge clk);
         cmd_dev_addr = ~dev; cmd_next_write = !wr; cmd_byte_addr = ~baddr; cmd_valid = 1'b1;
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      waited = 0;
      while (!done && waited < 20000) begin
         @(negedge clk);
         waited++;
      end
      check("R9", "done seen", done, 1);
      check("R9", "busy low with done", busy, 0);
      check("R7", "poll_count", poll_count, exp_count(k));
      check("R8", "timeout flag", timeout, to);
      check("R3", "start conditions", starts, exp_count(k));
      check("R3", "address byte mismatches", bad_addr, 0);
      check("R4", "stop conditions", stops, exp_stops(k, wr));
      if (wr && !to) begin
         check("R5", "byte address frames", got_baddr, 1);
         check("R5", "byte address value", last_baddr, baddr);
         check("R5", "SCL held low", scl_out, 0);
      end else begin
         check("R6", "byte address frames", got_baddr, 0);
         check("R6", "SCL high after stop", scl_out, 1);
      end
      check("R5", "SDA released at end", sda_pull_low, 0);
      if (poke) check("R10", "busy-time command ignored (addr)", bad_addr, 0);
      @(negedge clk);
      check("R9", "done one cycle", done, 0);
      check("R9", "timeout held", timeout, to);
   endtask

   initial begin
      #1500000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h1d5e_a7c3));
      dev_clr = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "SCL in reset", scl_out, 1);
      check("R1", "SDA in reset", sda_pull_low, 0);
      check("R1", "busy in reset", busy, 0);
      check("R1", "done in reset", done, 0);
      rst_n = 1'b1;
      dev_clr = 1'b0;
      repeat (2) @(negedge clk);
      check("R1", "busy idle", busy, 0);

      run_case(7'h50, 1'b1, 8'hA5, 1, 1'b0);               // R5 immediate ack
      run_case(7'h51, 1'b0, 8'h00, 1, 1'b0);               // R6 immediate ack
      run_case(7'h2B, 1'b1, 8'h3C, 3, 1'b0);               // R4 retries then write
      run_case(7'h7F, 1'b0, 8'hFF, MAX_POLLS, 1'b0);       // ack on last allowed attempt
      run_case(7'h00, 1'b1, 8'h81, MAX_POLLS + 1, 1'b0);   // R8 timeout
      run_case(7'h33, 1'b0, 8'h12, 4, 1'b1);               // R10 poke while busy
      run_case(7'h44, 1'b1, 8'h9E, 2, 1'b1);               // R10 poke while busy

      for (int i = 0; i < 8; i++) begin
         logic [6:0] d;
         logic [7:0] b;
         bit w;
         int k;
         d = 7'($urandom);
         b = 8'($urandom);
         w = 1'($urandom);
         k = 1 + int'($urandom % (MAX_POLLS + 2));
         run_case(d, w, b, k, 1'($urandom));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule